// File: doc/BRIEF.md
# Index-Addressed Prescaled System Counter

This block is a free-running 64-bit system counter with a per-CPU compare stage, reached from a host through only two bus words. The host first writes a register index to the index port. A later read or write of the data port then acts on the internal register that index selects. The selection stays in place until the index port is written again, so a run of data accesses can follow a single index write.

The control register holds a global run bit and a three-bit one-hot prescaler select. The select divides the input clock by 1, 2 or 4 to make the count tick. With a 26 MHz input and divide-by-2 selected, the count advances at 13 MHz. Each CPU has a 64-bit compare register. Each CPU also has a bit in a shared interrupt-enable register. Each CPU gets one level-high interrupt line. Clearing enable bits only masks delivery: the counter never stops for it, because other agents depend on it.

Software should program a compare value at least 3 ticks ahead of the count, with a delta of no more than 0xFFFFFFFF.

Top module: `idx_sys_timer`

## Requirements
- R1: `bus_addr2`=1 selects the index port (byte offset 0x4) and `bus_addr2`=0 selects the data port (offset 0x0). A write to the index port stores `bus_wdata[7:0]` as the current index. A read of the index port returns that index, zero-extended. The index resets to 0.
- R2: Index 0x00 is the control register. Bit 0 is the run bit and bits 10:8 are the prescaler select. Both fields read back exactly as written. All other bits read as zero. The register resets to 0.
- R3: The count resets to 0 and is never cleared after reset. While the run bit is 0 the count holds its value. While the run bit is 1 the count advances by exactly one per prescaler period.
- R4: Select 3'b001 divides by 1, 3'b010 divides by 2 and 3'b100 divides by 4. Let the run bit be written to 1 at clock edge E0, with the divider idle. Then k edges later the count has grown by floor(k / divisor). At divide-by-2, a 26 MHz input therefore gives a 13 MHz count.
- R5: A select value that is zero or has more than one bit set divides by 1. It still reads back as written.
- R6: Index 0x30 is the interrupt-enable mask, with bit n for CPU n. Bits at or above NCPU read as zero. A read, a modify and a write-back leave the other bits intact.
- R7: Index 0x08 reads count bits 31:0 and index 0x0C reads count bits 63:32. Writes to these indices are ignored.
- R8: The compare value of CPU n is at index 0x40+8n (bits 31:0) and index 0x44+8n (bits 63:32). It is a full 64-bit value and resets to all ones.
- R9: `irq_o[n]` is high in a cycle exactly when mask bit n is set and the count is at or past compare n. The line reflects the state that the preceding clock edge wrote. A count step and a compare write on the same edge are judged on both new values.
- R10: A compare value written 3 ticks ahead of a halted count, with the count then started at divide-by-1, raises the line on the third edge and not before.
- R11: Clearing mask bit n drops `irq_o[n]` in the next cycle. The count keeps advancing.
- R12: A data access to any index not listed above reads as zero and changes no register.
- R13: Writing a compare value ahead of the count clears that CPU's line in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this block |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr2 | input | 1 | Address bit 2: 0 = data port, 1 = index port |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from the address and the current index |
| irq_o | output | NCPU (4) | Level-high interrupt per CPU |

## Verification
Two functions can land on the same clock edge: the counter taking a step and a data-port write of a new compare value. The bench halts the count, reads it back as c, and restarts it at divide-by-1. It then aims a compare write so that the write lands on the edge where the count becomes c+2. A compare of c+2 must raise the line in that very cycle. A compare of c+3 must keep the line low for one cycle and then raise it. A design that judges either the old count or the old compare fails one of the two cases.

// File: rtl/idx_sys_timer_pkg.sv
package idx_sys_timer_pkg;

    localparam int IDX_W = 8;
    localparam int SEL_W = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL     = 8'h00;
    localparam logic [IDX_W-1:0] IDX_CNT_LO   = 8'h08;
    localparam logic [IDX_W-1:0] IDX_CNT_HI   = 8'h0C;
    localparam logic [IDX_W-1:0] IDX_IRQ_EN   = 8'h30;
    localparam logic [IDX_W-1:0] IDX_CMP_BASE = 8'h40;
    localparam int unsigned      CMP_STRIDE   = 8;
    localparam int unsigned      CMP_HI_OFS   = 4;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SEL_LSB = 8;

    localparam logic [SEL_W-1:0] SEL_DIV1 = 3'b001;
    localparam logic [SEL_W-1:0] SEL_DIV2 = 3'b010;
    localparam logic [SEL_W-1:0] SEL_DIV4 = 3'b100;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             run;
    } ctrl_t;

    function automatic logic [IDX_W-1:0] cmp_index(input int unsigned cpu, input logic hi);
        return IDX_CMP_BASE + IDX_W'(cpu * CMP_STRIDE) + (hi ? IDX_W'(CMP_HI_OFS) : IDX_W'(0));
    endfunction

endpackage

// File: rtl/idx_sys_timer_prescale.sv
module idx_sys_timer_prescale
    import idx_sys_timer_pkg::*;
#(
    parameter int MAX_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PW = $clog2(MAX_DIV);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [PW-1:0] limit;

    // Non-one-hot selections fall back to divide-by-1
    always_comb begin
        case (sel_i)
            SEL_DIV2: limit = PW'(1);
            SEL_DIV4: limit = PW'(3);
            default:  limit = '0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.phase >= limit);
        if (!run_i) begin
            st_d.phase = '0;
        end else if (tick_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a slow divisor never ticks on two consecutive cycles
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_o) && $stable(sel_i) && (sel_i == SEL_DIV2 || sel_i == SEL_DIV4)) |-> !tick_o);

endmodule

// File: rtl/idx_sys_timer_count.sv
module idx_sys_timer_count #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the count only ever moves forward by one
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + CW'(1)));

    // R3: every tick lands on the count
    assert_tick_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick_i) |-> (cnt_o == $past(cnt_o) + CW'(1)));

endmodule

// File: rtl/idx_sys_timer_cmp_chan.sv
module idx_sys_timer_cmp_chan #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [CW/2-1:0] wdata_i,
    input  logic          mask_nxt_i,
    input  logic [CW-1:0] cnt_nxt_i,
    output logic [CW-1:0] cmp_o,
    output logic          irq_o
);
    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cmp;
        logic          irq;
    } chan_st_t;

    chan_st_t st_d, st_q;

    // Level is judged on the values the coming edge will store
    always_comb begin
        st_d = st_q;
        if (wr_lo_i) begin
            st_d.cmp[HW-1:0] = wdata_i;
        end
        if (wr_hi_i) begin
            st_d.cmp[CW-1:HW] = wdata_i;
        end
        st_d.irq = mask_nxt_i && (cnt_nxt_i >= st_d.cmp);
    end

    assign cmp_o = st_q.cmp;
    assign irq_o = st_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: no line without its mask bit
    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mask_nxt_i));

    // R13: a fresh compare ahead of the count leaves the line low
    assert_new_cmp_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_lo_i || wr_hi_i) && (st_q.cmp > $past(cnt_nxt_i))) |-> !irq_o);

endmodule

// File: rtl/idx_sys_timer.sv
module idx_sys_timer
    import idx_sys_timer_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic            bus_addr2,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NCPU-1:0] irq_o
);
    localparam int CW = 2 * DW;
    localparam logic [DW-1:0] CTRL_RD_MASK =
        DW'((1 << CTRL_RUN_BIT) | (((1 << SEL_W) - 1) << CTRL_SEL_LSB));

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        ctrl_t            ctrl;
        logic [NCPU-1:0]  mask;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          idx_wr;
    logic          data_wr;
    logic          tick;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] cmp_w [NCPU];

    assign idx_wr  = bus_sel && bus_we && bus_addr2;
    assign data_wr = bus_sel && bus_we && !bus_addr2;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            st_d.idx = bus_wdata[IDX_W-1:0];
        end
        if (data_wr) begin
            case (st_q.idx)
                IDX_CTRL: begin
                    st_d.ctrl.run = bus_wdata[CTRL_RUN_BIT];
                    st_d.ctrl.sel = bus_wdata[CTRL_SEL_LSB +: SEL_W];
                end
                IDX_IRQ_EN: st_d.mask = bus_wdata[NCPU-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    idx_sys_timer_prescale #(
        .MAX_DIV (4)
    ) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.ctrl.run),
        .sel_i  (st_q.ctrl.sel),
        .tick_o (tick)
    );

    idx_sys_timer_count #(
        .CW (CW)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt)
    );

    for (genvar n = 0; n < NCPU; n++) begin : g_chan
        logic wr_lo;
        logic wr_hi;
        assign wr_lo = data_wr && (st_q.idx == cmp_index(n, 1'b0));
        assign wr_hi = data_wr && (st_q.idx == cmp_index(n, 1'b1));

        idx_sys_timer_cmp_chan #(
            .CW (CW)
        ) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo_i    (wr_lo),
            .wr_hi_i    (wr_hi),
            .wdata_i    (bus_wdata),
            .mask_nxt_i (st_d.mask[n]),
            .cnt_nxt_i  (cnt_nxt),
            .cmp_o      (cmp_w[n]),
            .irq_o      (irq_o[n])
        );
    end

    // Read path: index port, then fixed registers, then compare slots
    always_comb begin
        bus_rdata = '0;
        if (bus_addr2) begin
            bus_rdata[IDX_W-1:0] = st_q.idx;
        end else begin
            case (st_q.idx)
                IDX_CTRL: begin
                    bus_rdata[CTRL_RUN_BIT]              = st_q.ctrl.run;
                    bus_rdata[CTRL_SEL_LSB +: SEL_W]     = st_q.ctrl.sel;
                end
                IDX_CNT_LO: bus_rdata = cnt_q[DW-1:0];
                IDX_CNT_HI: bus_rdata = cnt_q[CW-1:DW];
                IDX_IRQ_EN: bus_rdata[NCPU-1:0] = st_q.mask;
                default: begin
                    for (int n = 0; n < NCPU; n++) begin
                        if (st_q.idx == cmp_index(n, 1'b0)) begin
                            bus_rdata = cmp_w[n][DW-1:0];
                        end else if (st_q.idx == cmp_index(n, 1'b1)) begin
                            bus_rdata = cmp_w[n][CW-1:DW];
                        end
                    end
                end
            endcase
        end
    end

    // R2: reserved control bits never show on a read
    assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_addr2 && st_q.idx == IDX_CTRL) |-> ((bus_rdata & ~CTRL_RD_MASK) == '0));

    // R3: with the run bit clear the count holds
    assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.ctrl.run) |-> $stable(cnt_q));

endmodule

// File: tb/idx_sys_timer_tb_top.sv
module idx_sys_timer_tb_top;
    localparam int NCPU = 4;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic            bus_addr2 = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NCPU-1:0] irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    idx_sys_timer #(.NCPU(NCPU), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr2 (bus_addr2),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    localparam logic [7:0] I_CTRL = 8'h00, I_CLO = 8'h08, I_CHI = 8'h0C, I_MASK = 8'h30;

    function automatic logic [7:0] cmp_idx(input int cpu, input bit hi);
        return 8'(8'h40 + cpu * 8 + (hi ? 4 : 0));
    endfunction

    // prescaler rows: select, idle cycles after index write, divisor
    typedef struct packed {
        logic [2:0] sel;
        logic [7:0] idle;
        logic [2:0] div;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'b001, 8'd9, 3'd1},
        '{3'b010, 8'd9, 3'd2},
        '{3'b100, 8'd9, 3'd4},
        '{3'b100, 8'd2, 3'd4},
        '{3'b010, 8'd0, 3'd2},
        '{3'b000, 8'd5, 3'd1},
        '{3'b011, 8'd6, 3'd1},
        '{3'b110, 8'd7, 3'd1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic a2, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr2 = a2; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a2, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr2 = a2;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic setreg(input logic [7:0] idx, input logic [31:0] d);
        wr(1'b1, {24'd0, idx});
        wr(1'b0, d);
    endtask

    task automatic getreg(input logic [7:0] idx, output logic [31:0] d);
        wr(1'b1, {24'd0, idx});
        rd(1'b0, d);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, c, a, b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R9 irq after reset", 64'(irq_o), 64'h0);
        rd(1'b1, d); chk("R1 index reset", 64'(d), 64'h0);
        rd(1'b0, d); chk("R2 ctrl reset", 64'(d), 64'h0);
        getreg(I_CLO, d); chk("R3 count reset", 64'(d), 64'h0);
        getreg(cmp_idx(0, 1'b0), d); chk("R8 compare reset lo", 64'(d), 64'hFFFF_FFFF);
        getreg(cmp_idx(0, 1'b1), d); chk("R8 compare reset hi", 64'(d), 64'hFFFF_FFFF);

        // Control readback and reserved bits
        setreg(I_CTRL, 32'h0000_0600);
        rd(1'b0, d); chk("R2 ctrl readback", 64'(d), 64'h600);
        setreg(I_CTRL, 32'hFFFF_FFFE);
        rd(1'b0, d); chk("R2 ctrl reserved zero", 64'(d), 64'h700);
        wr(1'b1, 32'h0000_0130);
        rd(1'b1, d); chk("R1 index readback", 64'(d), 64'h30);

        // Unmapped index
        setreg(8'h10, 32'hDEAD_BEEF);
        rd(1'b0, d); chk("R12 unmapped read", 64'(d), 64'h0);
        getreg(I_CTRL, d); chk("R12 ctrl untouched", 64'(d), 64'h700);

        // Mask register
        setreg(I_MASK, 32'h0000_00FF);
        rd(1'b0, d); chk("R6 mask width", 64'(d), 64'hF);
        rd(1'b0, d);
        wr(1'b0, d & ~32'h2);
        rd(1'b0, d); chk("R6 mask rmw", 64'(d), 64'hD);
        wr(1'b0, 32'h0);

        // Frozen while not running
        getreg(I_CLO, a);
        repeat (5) @(negedge clk);
        rd(1'b0, b); chk("R3 frozen while stopped", 64'(b), 64'(a));

        // Prescaler table
        foreach (VEC[i]) begin
            logic [31:0] base;
            setreg(I_CTRL, 32'h0);
            getreg(I_CLO, base);
            setreg(I_CTRL, {21'd0, VEC[i].sel, 8'h01});
            wr(1'b1, {24'd0, I_CLO});
            repeat (int'(VEC[i].idle)) @(negedge clk);
            rd(1'b0, d);
            chk((VEC[i].sel inside {3'b001, 3'b010, 3'b100}) ? "R4 prescale rate" : "R5 fallback rate",
                64'(d), 64'(base + (32'(VEC[i].idle) + 32'd1) / 32'(VEC[i].div)));
        end

        // Count register: upper half and ignored writes
        setreg(I_CTRL, 32'h0);
        getreg(I_CHI, d); chk("R7 count hi", 64'(d), 64'h0);
        getreg(I_CLO, c);
        wr(1'b0, c + 32'd100);
        rd(1'b0, d); chk("R7 count write ignored", 64'(d), 64'(c));

        // Compare reached, 3 ticks ahead
        setreg(cmp_idx(0, 1'b1), 32'h0);
        setreg(cmp_idx(0, 1'b0), c + 32'd3);
        setreg(I_MASK, 32'h1);
        chk("R9 compare ahead low", 64'(irq_o), 64'h0);
        setreg(I_CTRL, 32'h0000_0101);
        @(negedge clk);
        @(negedge clk);
        chk("R10 not yet at c+2", 64'(irq_o[0]), 64'h0);
        @(negedge clk);
        chk("R10 raised at c+3", 64'(irq_o[0]), 64'h1);
        chk("R9 other lines low", 64'(irq_o[3:1]), 64'h0);

        // Masking keeps counter running
        setreg(I_MASK, 32'h0);
        chk("R11 mask drops line", 64'(irq_o[0]), 64'h0);
        getreg(I_CLO, a);
        repeat (4) @(negedge clk);
        rd(1'b0, b); chk("R11 count keeps running", 64'(b), 64'(a + 32'd4));
        setreg(I_MASK, 32'h1);
        chk("R9 unmask restores level", 64'(irq_o[0]), 64'h1);

        // New compare clears
        getreg(I_CLO, c);
        setreg(cmp_idx(0, 1'b0), c + 32'd1000);
        chk("R13 new compare clears", 64'(irq_o[0]), 64'h0);

        // Full 64-bit compare
        setreg(cmp_idx(1, 1'b1), 32'h1);
        setreg(cmp_idx(1, 1'b0), 32'h0);
        setreg(I_MASK, 32'hF);
        chk("R8 upper compare bits matter", 64'(irq_o[1]), 64'h0);
        setreg(cmp_idx(1, 1'b1), 32'h0);
        chk("R9 compare zero reached", 64'(irq_o[1]), 64'h1);

        // Compare write and count step on the same edge
        setreg(cmp_idx(2, 1'b1), 32'h0);
        setreg(I_CTRL, 32'h0);
        getreg(I_CLO, c);
        setreg(I_CTRL, 32'h0000_0101);
        wr(1'b1, {24'd0, cmp_idx(2, 1'b0)});
        wr(1'b0, c + 32'd2);
        chk("R9 same-edge compare equal", 64'(irq_o[2]), 64'h1);

        setreg(cmp_idx(3, 1'b1), 32'h0);
        setreg(I_CTRL, 32'h0);
        getreg(I_CLO, c);
        setreg(I_CTRL, 32'h0000_0101);
        wr(1'b1, {24'd0, cmp_idx(3, 1'b0)});
        wr(1'b0, c + 32'd3);
        chk("R9 same-edge compare one ahead", 64'(irq_o[3]), 64'h0);
        @(negedge clk);
        chk("R9 one tick later", 64'(irq_o[3]), 64'h1);

        finish_run();
    end

endmodule